// File: doc/BRIEF.md
# Four-Lane Stereo Audio Serial Port (Master)

This block is a master-mode serial audio port. From a single master clock it generates one bit clock and one word-select signal. Four output data lanes and four input data lanes share these two signals. Each lane carries a left/right pair, so the port moves eight output channels and eight input channels per sample frame.

Transmit samples are presented on a flat parallel bus. The port captures them at the start of each frame and reports the capture with a one-cycle strobe. The frame format follows I2S: word select is low for the left word and high for the right word, it changes one bit clock ahead of each MSB, samples are 24 bits sent MSB first, and every unused slot carries zero. Output lines change on the falling edge of the bit clock. Input lines are sampled on the rising edge. Received samples are presented together with a one-cycle valid pulse at the end of each frame.

A mode input selects a bit clock of 128 or 256 times the sample rate, which gives a half-frame of 64 or 128 bit clocks. A change of mode is applied only when a new frame begins.

Top module: `mlane_i2s_port`

## Requirements
- R1: While reset is held and right after it is released, sclk, ws, sdo, rx_valid and frame_strobe are all low.
- R2: sclk is the master clock divided by 2*DIV_HALF with equal high and low times (4 master clocks per bit at the default DIV_HALF=2).
- R3: With mode_256=0 each word-select half lasts 64 bit clocks. With mode_256=1 it lasts 128.
- R4: Output lane L carries channel 2L during the left word and channel 2L+1 during the right word. Channel c is tx_data[c*24 +: 24], and it is sent MSB first starting in slot 0 of its half.
- R5: Bit slots 24 and above of every half-frame drive sdo low.
- R6: ws is low for the left word and high for the right word, and it switches during the last bit slot of the preceding word.
- R7: sdi is sampled on the sclk rising edge with the same slot, lane and channel mapping as transmit, and the samples appear on rx_data (channel c at rx_data[c*24 +: 24]).
- R8: Each input lane fills only its own two channels of rx_data.
- R9: frame_strobe pulses for one master clock at the start of each frame, which is when tx_data is captured. The spacing between pulses is (frame bit count)*2*DIV_HALF master clocks.
- R10: A change on mode_256 during a frame does not alter that frame. It takes effect from the next frame.
- R11: rx_valid pulses for one master clock per frame, after the last bit slot. rx_data holds its value between pulses.
- R12: ws and sdo change only in the master-clock cycle in which sclk falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_256 | input | 1 | 0: bit clock is 128x sample rate; 1: bit clock is 256x |
| tx_data | input | 192 | Eight 24-bit transmit samples, channel c at [c*24 +: 24] |
| frame_strobe | output | 1 | One-cycle pulse when tx_data is captured at frame start |
| rx_data | output | 192 | Eight 24-bit received samples, same layout as tx_data |
| rx_valid | output | 1 | One-cycle pulse when a complete frame is on rx_data |
| sclk | output | 1 | Shared bit clock |
| ws | output | 1 | Shared word select, low = left |
| sdo | output | 4 | Serial output lanes |
| sdi | input | 4 | Serial input lanes |

## Verification
The embedded properties check the following on every cycle: ws and the output lanes move only with a falling bit clock, the bit clock toggles only when the divider wraps, the mode register changes only at a frame start, padding slots carry zero, and rx_valid is a single-cycle pulse that follows a rising bit clock. Some behaviours can be seen only in the bench's scenarios, where the serial stream is decoded independently of the design. These are whether the right sample reaches the right lane and side in MSB-first order, the measured half-frame length in each mode, the received data under loopback, crossed lanes and constant input, and how a mode switch in mid-frame lines up with the strobe spacing.

// File: rtl/mlane_i2s_pkg.sv
package mlane_i2s_pkg;
  localparam int SLOT_W = 8;
  localparam int HALF_NARROW = 64;
  localparam int HALF_WIDE = 128;

  typedef logic [SLOT_W-1:0] slot_t;

  // number of bit slots in one word-select half
  function automatic slot_t half_len(input logic wide);
    return wide ? slot_t'(HALF_WIDE) : slot_t'(HALF_NARROW);
  endfunction

  // index of the final slot in a frame
  function automatic slot_t last_slot(input logic wide);
    return wide ? slot_t'(2*HALF_WIDE-1) : slot_t'(2*HALF_NARROW-1);
  endfunction

  function automatic logic in_right(input slot_t s, input logic wide);
    return s >= half_len(wide);
  endfunction

  // bit position inside the current word (0 = MSB slot)
  function automatic slot_t word_pos(input slot_t s, input logic wide);
    return in_right(s, wide) ? slot_t'(s - half_len(wide)) : s;
  endfunction

  // ws level during slot s: it leads the data by one slot
  function automatic logic ws_level(input slot_t s, input logic wide);
    slot_t n;
    n = (s == last_slot(wide)) ? '0 : slot_t'(s + 1'b1);
    return in_right(n, wide);
  endfunction
endpackage

// File: rtl/mlane_i2s_clkgen.sv
module mlane_i2s_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(DIV_HALF-1));
  assign rise_evt = wrap & ~sclk;
  assign fall_evt = wrap & sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R2: bit clock only toggles when the divider wraps
  p_sclk_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(wrap));
endmodule

// File: rtl/mlane_i2s_framer.sv
module mlane_i2s_framer
  import mlane_i2s_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fall_evt,
  input  logic  mode_256,
  output slot_t slot_q,
  output logic  mode_q,
  output slot_t slot_nxt,
  output logic  mode_nxt,
  output logic  frame_start,
  output logic  ws,
  output logic  started
);
  logic wrap;

  assign wrap        = (slot_q == last_slot(mode_q));
  assign frame_start = fall_evt & wrap;

  always_comb begin
    slot_nxt = slot_q;
    mode_nxt = mode_q;
    if (fall_evt) begin
      slot_nxt = wrap ? '0 : slot_t'(slot_q + 1'b1);
      mode_nxt = wrap ? mode_256 : mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= last_slot(1'b0);
      mode_q  <= 1'b0;
      ws      <= 1'b0;
      started <= 1'b0;
    end else if (fall_evt) begin
      slot_q  <= slot_nxt;
      mode_q  <= mode_nxt;
      ws      <= ws_level(slot_nxt, mode_nxt);
      started <= 1'b1;
    end
  end

  // R10: mode register moves only at a frame start
  p_mode_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(frame_start));
  // R12: word select moves only with a falling bit clock
  p_ws_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $past(fall_evt));
endmodule

// File: rtl/mlane_i2s_tx.sv
module mlane_i2s_tx
  import mlane_i2s_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fall_evt,
  input  logic                  frame_start,
  input  logic                  started,
  input  slot_t                 slot_q,
  input  logic                  mode_q,
  input  slot_t                 slot_nxt,
  input  logic                  mode_nxt,
  input  logic [LANES*2*SW-1:0] tx_data,
  output logic [LANES-1:0]      sdo,
  output logic                  strobe
);
  slot_t nxt_pos;
  logic  nxt_right;

  assign nxt_pos   = word_pos(slot_nxt, mode_nxt);
  assign nxt_right = in_right(slot_nxt, mode_nxt);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SW-1:0] sh_l, sh_r, cur_l, cur_r, smp;
    logic          nbit, bit_q;

    always_comb begin
      cur_l = frame_start ? tx_data[(2*g)*SW +: SW]   : sh_l;
      cur_r = frame_start ? tx_data[(2*g+1)*SW +: SW] : sh_r;
      smp   = nxt_right ? cur_r : cur_l;
      nbit  = 1'b0;
      if (int'(nxt_pos) < SW) nbit = smp[SW-1-int'(nxt_pos)];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_l  <= '0;
        sh_r  <= '0;
        bit_q <= 1'b0;
      end else if (fall_evt) begin
        sh_l  <= cur_l;
        sh_r  <= cur_r;
        bit_q <= nbit;
      end
    end

    assign sdo[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= frame_start;
  end

  // R5: padding slots of each half carry zero on every lane
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && int'(word_pos(slot_q, mode_q)) >= SW) |-> (sdo == '0));
  // R9: strobe follows a frame start and is one cycle wide
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/mlane_i2s_rx.sv
module mlane_i2s_rx
  import mlane_i2s_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise_evt,
  input  logic                  started,
  input  slot_t                 slot_q,
  input  logic                  mode_q,
  input  logic [LANES-1:0]      sdi,
  output logic [LANES*2*SW-1:0] rx_data,
  output logic                  rx_valid
);
  slot_t cur_pos;
  logic  cur_right, take, done;

  assign cur_pos   = word_pos(slot_q, mode_q);
  assign cur_right = in_right(slot_q, mode_q);
  assign take      = rise_evt & started & (int'(cur_pos) < SW);
  assign done      = rise_evt & started & (slot_q == last_slot(mode_q));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SW-1:0] acc_l, acc_r, out_l, out_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_l <= '0;
        acc_r <= '0;
        out_l <= '0;
        out_r <= '0;
      end else begin
        if (take) begin
          if (cur_right) acc_r[SW-1-int'(cur_pos)] <= sdi[g];
          else           acc_l[SW-1-int'(cur_pos)] <= sdi[g];
        end
        if (done) begin
          out_l <= acc_l;
          out_r <= acc_r;
        end
      end
    end

    assign rx_data[(2*g)*SW +: SW]   = out_l;
    assign rx_data[(2*g+1)*SW +: SW] = out_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_valid <= 1'b0;
    else        rx_valid <= done;
  end

  // R11: valid is a single pulse that follows a rising bit clock
  p_valid_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise_evt));
  p_valid_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R11: received data only moves together with valid
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);
endmodule

// File: rtl/mlane_i2s_port.sv
module mlane_i2s_port
  import mlane_i2s_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SW       = 24,
  parameter int DIV_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_256,
  input  logic [LANES*2*SW-1:0] tx_data,
  output logic                  frame_strobe,
  output logic [LANES*2*SW-1:0] rx_data,
  output logic                  rx_valid,
  output logic                  sclk,
  output logic                  ws,
  output logic [LANES-1:0]      sdo,
  input  logic [LANES-1:0]      sdi
);
  logic  rise_evt, fall_evt, frame_start, started;
  logic  mode_q, mode_nxt;
  slot_t slot_q, slot_nxt;

  mlane_i2s_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk),
    .rise_evt(rise_evt), .fall_evt(fall_evt));

  mlane_i2s_framer u_frm (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .mode_256(mode_256),
    .slot_q(slot_q), .mode_q(mode_q), .slot_nxt(slot_nxt),
    .mode_nxt(mode_nxt), .frame_start(frame_start), .ws(ws),
    .started(started));

  mlane_i2s_tx #(.LANES(LANES), .SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
    .frame_start(frame_start), .started(started), .slot_q(slot_q),
    .mode_q(mode_q), .slot_nxt(slot_nxt), .mode_nxt(mode_nxt),
    .tx_data(tx_data), .sdo(sdo), .strobe(frame_strobe));

  mlane_i2s_rx #(.LANES(LANES), .SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .started(started),
    .slot_q(slot_q), .mode_q(mode_q), .sdi(sdi),
    .rx_data(rx_data), .rx_valid(rx_valid));

  // R12: output lanes move only with a falling bit clock
  p_sdo_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $fell(sclk));
  // R9: capture strobe coincides with the cycle after the bit clock fell
  p_strobe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (!sclk && !ws));
endmodule

// File: tb/tb_mlane_i2s_port.sv
module tb_mlane_i2s_port;
  localparam int LANES = 4;
  localparam int SW    = 24;
  localparam int NCH   = 2*LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_256 = 1'b0;
  logic [NCH*SW-1:0] tx_data = '0;
  logic [NCH*SW-1:0] rx_data;
  logic frame_strobe, rx_valid, sclk, ws;
  logic [LANES-1:0] sdo, sdi;
  int sdi_sel = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  always_comb begin
    case (sdi_sel)
      0:       sdi = sdo;
      1:       sdi = {sdo[0], sdo[LANES-1:1]};
      2:       sdi = '1;
      default: sdi = '0;
    endcase
  end

  mlane_i2s_port dut (
    .clk(clk), .rst_n(rst_n), .mode_256(mode_256), .tx_data(tx_data),
    .frame_strobe(frame_strobe), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk(sclk), .ws(ws), .sdo(sdo), .sdi(sdi));

  // ---------------- independent stream monitor ----------------
  int cyc = 0;
  logic p_sclk = 1'b0, p_ws = 1'b0;
  logic [LANES-1:0] p_sdo = '0;
  int last_rise = 0, sclk_per = 0, hi_len = 0, cur_hi = 0;
  int k = 1000;
  logic cur_ch = 1'b0;
  logic m_ws_prev = 1'b0;
  int half_meas = 0, pad_err = 0, edge_err = 0, done_cnt = 0;
  logic [SW-1:0] dec [LANES][2];
  logic [SW-1:0] got [LANES][2];
  int last_str = 0, str_int = 0, str_cnt = 0;
  int rxv_cnt = 0, rxv_wide = 0;
  logic p_rxv = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ((ws != p_ws || sdo != p_sdo) && !(p_sclk && !sclk)) edge_err++;
      if (sclk) cur_hi++;
      if (!sclk && p_sclk) begin hi_len = cur_hi; cur_hi = 0; end
      if (sclk && !p_sclk) begin
        sclk_per = cyc - last_rise;
        last_rise = cyc;
        if (k < SW) begin
          for (int l = 0; l < LANES; l++) dec[l][cur_ch][SW-1-k] = sdo[l];
        end else if (k < 1000 && sdo != '0) pad_err++;
        if (ws != m_ws_prev) begin
          if (k < 1000) half_meas = k + 1;
          if (cur_ch == 1'b1 && k < 1000) begin
            for (int l = 0; l < LANES; l++) begin
              got[l][0] = dec[l][0];
              got[l][1] = dec[l][1];
            end
            done_cnt++;
          end
          cur_ch = ws;
          k = 0;
        end else if (k < 1000) k++;
        m_ws_prev = ws;
      end
      if (frame_strobe) begin str_int = cyc - last_str; last_str = cyc; str_cnt++; end
      if (rx_valid) rxv_cnt++;
      if (rx_valid && p_rxv) rxv_wide++;
    end
    p_sclk = sclk; p_ws = ws; p_sdo = sdo; p_rxv = rx_valid;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input int n);
    int t;
    t = done_cnt;
    while (done_cnt < t + n) @(negedge clk);
  endtask

  task automatic wait_rxv(input int n);
    int t;
    t = rxv_cnt;
    while (rxv_cnt < t + n) @(negedge clk);
  endtask

  task automatic wait_str(input int n);
    int t;
    t = str_cnt;
    while (str_cnt < t + n) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] pat(input int seed, input int c);
    return SW'(32'h9E3779 * (c + 1) ^ (seed * 32'h10101)) | SW'(1);
  endfunction

  function automatic logic [NCH*SW-1:0] build(input int seed);
    logic [NCH*SW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = pat(seed, c);
    return v;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check("R1 sclk", sclk == 0, sclk, 0);
    check("R1 ws", ws == 0, ws, 0);
    check("R1 sdo", sdo == 0, sdo, 0);
    check("R1 rx_valid/strobe", (rx_valid | frame_strobe) == 0, {rx_valid, frame_strobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {sclk, ws, sdo, rx_valid, frame_strobe} == '0,
          {sclk, ws, sdo, rx_valid, frame_strobe}, 0);
  endtask

  task automatic t_clock();
    repeat (40) @(negedge clk);
    check("R2 sclk period", sclk_per == 4, sclk_per, 4);
    check("R2 sclk high time", hi_len == 2, hi_len, 2);
  endtask

  task automatic t_tx(input logic wide, input int seed);
    logic [NCH*SW-1:0] v;
    v = build(seed);
    mode_256 = wide;
    tx_data = v;
    wait_done(3);
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < 2; s++)
        check($sformatf("R4/R6 lane%0d side%0d", l, s),
              got[l][s] == v[(2*l+s)*SW +: SW], got[l][s], v[(2*l+s)*SW +: SW]);
    check("R3 half length", half_meas == (wide ? 128 : 64), half_meas, wide ? 128 : 64);
    check("R5 padding zero", pad_err == 0, pad_err, 0);
    check("R9 strobe spacing", str_int == (wide ? 1024 : 512), str_int, wide ? 1024 : 512);
  endtask

  task automatic t_rx(input int sel, input int seed);
    logic [NCH*SW-1:0] v, e;
    v = build(seed);
    tx_data = v;
    sdi_sel = sel;
    wait_rxv(2);
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++)
      for (int s = 0; s < 2; s++) begin
        if (sel == 0)      e[(2*l+s)*SW +: SW] = v[(2*l+s)*SW +: SW];
        else if (sel == 1) e[(2*l+s)*SW +: SW] = v[(2*((l+1)%LANES)+s)*SW +: SW];
        else               e[(2*l+s)*SW +: SW] = (sel == 2) ? '1 : '0;
      end
    for (int c = 0; c < NCH; c++)
      check($sformatf("%s rx ch%0d sel%0d", sel == 1 ? "R8" : "R7", c, sel),
            rx_data[c*SW +: SW] == e[c*SW +: SW], rx_data[c*SW +: SW], e[c*SW +: SW]);
    check("R11 rx_valid single cycle", rxv_wide == 0, rxv_wide, 0);
  endtask

  task automatic t_mode_switch();
    mode_256 = 1'b0;
    wait_str(2);
    repeat (100) @(negedge clk);
    mode_256 = 1'b1;
    wait_str(1);
    check("R10 frame in flight keeps old length", str_int == 512, str_int, 512);
    wait_str(1);
    check("R10 next frame uses new length", str_int == 1024, str_int, 1024);
    repeat (300) @(negedge clk);
    mode_256 = 1'b0;
    wait_str(1);
    check("R10 wide frame completes", str_int == 1024, str_int, 1024);
    wait_str(1);
    check("R10 back to narrow", str_int == 512, str_int, 512);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_clock();
    t_tx(1'b0, 1);
    t_tx(1'b0, 7);
    t_tx(1'b1, 3);
    tx_data = {NCH{24'h800001}};
    wait_done(3);
    check("R4 MSB-first edge pattern", got[2][1] == 24'h800001, got[2][1], 24'h800001);
    mode_256 = 1'b0;
    t_rx(0, 11);
    t_rx(1, 12);
    t_rx(2, 13);
    t_rx(3, 14);
    t_mode_switch();
    check("R12 ws/sdo move only at falling sclk", edge_err == 0, edge_err, 0);
    finish_run();
  end
endmodule